// File: doc/BRIEF.md
# Scroll and VRAM Address Register File

This block holds the scroll state of a tile-based video generator. It keeps a 15-bit live VRAM address, a 15-bit staging latch, a 3-bit fine horizontal scroll and a one-bit write-phase toggle.

The CPU side has one register select and two strobes, one for writes and one for reads. Through them the CPU programs the scroll and address registers, each of which takes a pair of byte writes. The two registers share the write-phase toggle. Each byte lands in fixed bit fields of the staging latch. A second address write copies the whole latch into the live address at once.

The render side supplies the current scanline, the dot number and a rendering-enabled flag. While rendering is enabled, the block reloads the horizontal part of the live address at one fixed dot on every line. On the pre-render line it reloads the whole address across a window of dots. The live address drives the VRAM address path, and fine X drives the pixel shift-register selector.

Top module: `scroll_addr_regs`

## Requirements
- R1: While `rst_n` is low, the live address, the staging latch, fine X and the write-phase toggle all clear to zero.
- R2: `reg_sel` encodes 0 = control, 1 = status, 2 = scroll, 3 = address. A write (`cpu_wr`) to scroll or address flips the toggle. A read (`cpu_rd`) of status clears it. A control write leaves it unchanged. Toggle 0 means the first write of a pair and 1 means the second.
- R3: A first scroll write loads data[2:0] into fine X and data[7:3] into latch[4:0]. `fine_x` shows the new value in the cycle after the write edge. No other write changes fine X.
- R4: A second scroll write loads data[2:0] into latch[14:12] and data[7:3] into latch[9:5]. It leaves the live address unchanged.
- R5: A first address write clears latch[14] and loads data[5:0] into latch[13:8]. Data[7:6] are ignored. The live address is unchanged.
- R6: A second address write loads data[7:0] into latch[7:0]. The complete updated latch is then copied into `vaddr` at that same edge.
- R7: A control write loads data[1:0] into latch[11:10].
- R8: With rendering enabled, at dot 257 of any scanline, latch bit 10 and latch bits 4:0 are copied into `vaddr`. All other address bits keep their values.
- R9: With rendering enabled, on the pre-render line (default 261), the whole latch is copied into `vaddr` on every dot from 280 through 304 inclusive. This does not happen at dot 279, at dot 305, or on any other line.
- R10: With rendering disabled, no dot or scanline value changes `vaddr`.
- R11: When a second address write coincides with a render-time reload, the CPU copy wins. `vaddr` receives the latch with the CPU byte merged in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 scroll, 3 address |
| cpu_wdata | input | 8 | CPU write data |
| scanline | input | 9 | Current scanline number |
| dot | input | 9 | Current dot within the scanline |
| render_en | input | 1 | Background or sprite rendering enabled |
| vaddr | output | 15 | Live VRAM address |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The assertions assume that each CPU access lasts exactly one clock and that a status read is never issued together with a write, since both share one select. They also assume that the scanline and dot inputs describe a single position per cycle. The stimulus drives every access as a one-cycle strobe with one select value. Between accesses it parks the render inputs at line 0, dot 0, where no reload happens. It raises the render-side fields together with a CPU write only in the collision scenarios.

// File: rtl/scroll_addr_regs.sv
module scroll_addr_regs #(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int PRE_LINE    = 261,
  parameter int HCOPY_DOT   = 257,
  parameter int VCOPY_FIRST = 280,
  parameter int VCOPY_LAST  = 304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        cpu_wdata,
  input  logic [LINE_W-1:0] scanline,
  input  logic [DOT_W-1:0]  dot,
  input  logic              render_en,
  output logic [14:0]       vaddr,
  output logic [2:0]        fine_x
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_SCRL = 2'd2;
  localparam logic [1:0] SEL_ADDR = 2'd3;
  localparam logic [LINE_W-1:0] PRE_L = LINE_W'(PRE_LINE);
  localparam logic [DOT_W-1:0]  HDOT  = DOT_W'(HCOPY_DOT);
  localparam logic [DOT_W-1:0]  VLO   = DOT_W'(VCOPY_FIRST);
  localparam logic [DOT_W-1:0]  VHI   = DOT_W'(VCOPY_LAST);

  logic [14:0] t_q, t_next;
  logic        tog_q;

  wire wr_ctrl = cpu_wr && reg_sel == SEL_CTRL;
  wire wr_scrl = cpu_wr && reg_sel == SEL_SCRL;
  wire wr_addr = cpu_wr && reg_sel == SEL_ADDR;
  wire rd_stat = cpu_rd && reg_sel == SEL_STAT;

  wire addr_commit = wr_addr && tog_q;
  wire v_full  = render_en && scanline == PRE_L && dot >= VLO && dot <= VHI;
  wire v_horiz = render_en && dot == HDOT;

  always_comb begin
    t_next = t_q;
    if (wr_ctrl) t_next[11:10] = cpu_wdata[1:0];
    if (wr_scrl && !tog_q) t_next[4:0] = cpu_wdata[7:3];
    if (wr_scrl && tog_q) begin
      t_next[14:12] = cpu_wdata[2:0];
      t_next[9:5]   = cpu_wdata[7:3];
    end
    if (wr_addr && !tog_q) begin
      t_next[14]   = 1'b0;
      t_next[13:8] = cpu_wdata[5:0];
    end
    if (addr_commit) t_next[7:0] = cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      tog_q  <= 1'b0;
      vaddr  <= '0;
      fine_x <= '0;
    end else begin
      t_q <= t_next;
      if (rd_stat) tog_q <= 1'b0;
      else if (wr_scrl || wr_addr) tog_q <= ~tog_q;
      if (wr_scrl && !tog_q) fine_x <= cpu_wdata[2:0];
      if (addr_commit || v_full) vaddr <= t_next;
      else if (v_horiz) begin
        vaddr[10]  <= t_next[10];
        vaddr[4:0] <= t_next[4:0];
      end
    end
  end
endmodule

// File: rtl/scroll_addr_regs_chk.sv
module scroll_addr_regs_chk #(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int PRE_LINE    = 261,
  parameter int HCOPY_DOT   = 257,
  parameter int VCOPY_FIRST = 280,
  parameter int VCOPY_LAST  = 304
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [1:0]        reg_sel,
  input logic [LINE_W-1:0] scanline,
  input logic [DOT_W-1:0]  dot,
  input logic              render_en,
  input logic [14:0]       vaddr,
  input logic [2:0]        fine_x,
  input logic [14:0]       t_q,
  input logic              tog_q
);
  wire pair_wr  = cpu_wr && (reg_sel == 2'd2 || reg_sel == 2'd3);
  wire a2_wr    = cpu_wr && reg_sel == 2'd3 && tog_q;
  wire s1_wr    = cpu_wr && reg_sel == 2'd2 && !tog_q;
  wire st_rd    = cpu_rd && !cpu_wr && reg_sel == 2'd1;
  wire pre_win  = render_en && scanline == LINE_W'(PRE_LINE) &&
                  dot >= DOT_W'(VCOPY_FIRST) && dot <= DOT_W'(VCOPY_LAST);
  wire hdot     = render_en && dot == DOT_W'(HCOPY_DOT);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> vaddr == 15'd0 && fine_x == 3'd0 && t_q == 15'd0 && !tog_q);

  p_toggle_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_wr && !cpu_rd |=> tog_q != $past(tog_q));

  p_status_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> !tog_q);

  p_finex_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_wr |=> $stable(fine_x));

  p_addr_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a2_wr |=> vaddr == t_q);

  p_prerender_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_win |=> vaddr == t_q);

  p_horiz_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdot && !pre_win && !a2_wr |=>
      vaddr[4:0] == t_q[4:0] && vaddr[10] == t_q[10] &&
      vaddr[14:11] == $past(vaddr[14:11]) && vaddr[9:5] == $past(vaddr[9:5]));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en && !a2_wr |=> $stable(vaddr));
endmodule

bind scroll_addr_regs scroll_addr_regs_chk #(
  .LINE_W(LINE_W), .DOT_W(DOT_W), .PRE_LINE(PRE_LINE), .HCOPY_DOT(HCOPY_DOT),
  .VCOPY_FIRST(VCOPY_FIRST), .VCOPY_LAST(VCOPY_LAST)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .reg_sel(reg_sel),
  .scanline(scanline), .dot(dot), .render_en(render_en), .vaddr(vaddr),
  .fine_x(fine_x), .t_q(t_q), .tog_q(tog_q)
);

// File: tb/scroll_addr_regs_tb_top.sv
module scroll_addr_regs_tb_top;
  localparam logic [1:0] CTRL = 2'd0, STAT = 2'd1, SCRL = 2'd2, ADDR = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, render_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [8:0] scanline = 9'd0, dot = 9'd0;
  logic [14:0] vaddr;
  logic [2:0] fine_x;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scroll_addr_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .reg_sel(reg_sel),
    .cpu_wdata(cpu_wdata), .scanline(scanline), .dot(dot), .render_en(render_en),
    .vaddr(vaddr), .fine_x(fine_x)
  );

  task automatic step(input logic wr, input logic rd, input logic [1:0] sel,
                      input logic [7:0] d, input logic [8:0] ln,
                      input logic [8:0] dt, input logic en);
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; reg_sel = sel; cpu_wdata = d;
    scanline = ln; dot = dt; render_en = en;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0; reg_sel = 2'd0; cpu_wdata = 8'd0;
    scanline = 9'd0; dot = 9'd0; render_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    step(1'b1, 1'b0, sel, d, 9'd0, 9'd0, 1'b0);
  endtask
  task automatic rd_status();
    step(1'b0, 1'b1, STAT, 8'd0, 9'd0, 9'd0, 1'b0);
  endtask
  task automatic render(input logic [8:0] ln, input logic [8:0] dt, input logic en);
    step(1'b0, 1'b0, CTRL, 8'd0, ln, dt, en);
  endtask

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 vaddr", vaddr, 15'h0000);
    chk("R1 fine_x", {12'd0, fine_x}, 15'd0);
    render(9'd261, 9'd280, 1'b1);
    chk("R1 latch", vaddr, 15'h0000);
  endtask

  task automatic t_scroll();
    rd_status();
    wr(SCRL, 8'h7D);
    chk("R3 fine_x", {12'd0, fine_x}, 15'd5);
    chk("R4 vaddr kept", vaddr, 15'h0000);
    wr(SCRL, 8'h5E);
    chk("R4 vaddr kept", vaddr, 15'h0000);
    chk("R3 fine_x hold", {12'd0, fine_x}, 15'd5);
    render(9'd261, 9'd290, 1'b1);
    chk("R3 R4 latch", vaddr, 15'h616F);
  endtask

  task automatic t_addr();
    rd_status();
    wr(ADDR, 8'hFF);
    chk("R5 vaddr kept", vaddr, 15'h616F);
    wr(ADDR, 8'h12);
    chk("R5 R6 commit", vaddr, 15'h3F12);
    chk("R3 fine_x after addr", {12'd0, fine_x}, 15'd5);
  endtask

  task automatic t_toggle();
    rd_status();
    wr(ADDR, 8'h05);
    rd_status();
    wr(ADDR, 8'h21);
    chk("R2 status clears", vaddr, 15'h3F12);
    wr(ADDR, 8'h34);
    chk("R2 second write", vaddr, 15'h2134);
    rd_status();
    wr(ADDR, 8'h01);
    wr(CTRL, 8'h02);
    wr(ADDR, 8'h56);
    chk("R2 R7 ctrl keeps toggle", vaddr, 15'h0956);
  endtask

  task automatic t_hreload();
    rd_status();
    wr(ADDR, 8'h00);
    wr(ADDR, 8'h00);
    wr(SCRL, 8'hF8);
    wr(SCRL, 8'hFF);
    wr(CTRL, 8'h03);
    chk("R6 base", vaddr, 15'h0000);
    chk("R3 fine_x", {12'd0, fine_x}, 15'd0);
    render(9'd100, 9'd256, 1'b1);
    chk("R8 dot 256", vaddr, 15'h0000);
    render(9'd100, 9'd257, 1'b1);
    chk("R8 dot 257", vaddr, 15'h041F);
  endtask

  task automatic t_vwindow();
    render(9'd261, 9'd279, 1'b1);
    chk("R9 dot 279", vaddr, 15'h041F);
    render(9'd100, 9'd290, 1'b1);
    chk("R9 other line", vaddr, 15'h041F);
    render(9'd261, 9'd305, 1'b1);
    chk("R9 dot 305", vaddr, 15'h041F);
    render(9'd261, 9'd304, 1'b1);
    chk("R9 dot 304", vaddr, 15'h7FFF);
  endtask

  task automatic t_disabled();
    rd_status();
    wr(ADDR, 8'h00);
    wr(ADDR, 8'h00);
    wr(CTRL, 8'h01);
    render(9'd261, 9'd290, 1'b0);
    chk("R10 prerender off", vaddr, 15'h0000);
    render(9'd100, 9'd257, 1'b0);
    chk("R10 hdot off", vaddr, 15'h0000);
    render(9'd100, 9'd257, 1'b1);
    chk("R7 R8 nametable", vaddr, 15'h0400);
  endtask

  task automatic t_collide();
    rd_status();
    wr(ADDR, 8'h15);
    step(1'b1, 1'b0, ADDR, 8'hAB, 9'd100, 9'd257, 1'b1);
    chk("R11 vs hdot", vaddr, 15'h15AB);
    rd_status();
    wr(ADDR, 8'h2A);
    step(1'b1, 1'b0, ADDR, 8'h0C, 9'd261, 9'd290, 1'b1);
    chk("R11 vs window", vaddr, 15'h2A0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scroll();
    t_addr();
    t_toggle();
    t_hreload();
    t_vwindow();
    t_disabled();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule